// File: doc/BRIEF.md
# Multi-channel Serial DAC Frame Writer

This block turns a stream of per-channel value updates into write frames for a multi-channel serial DAC on a write-only, mode-0 SPI-style link. Each accepted request carries a channel index and a 16-bit value. The block builds a 24-bit word and shifts it out MSB first on a serial clock at one quarter of the system clock. The word is framed by an active-low sync line.

The block keeps a shadow copy of the last value sent to each channel. A request that would repeat that value is consumed without producing a frame, which saves link time when a controller sweeps all channels on every tick. After the channel writes of a batch, a commit input requests one active-low load pulse. That pulse moves every DAC output to its new value at the same moment. A commit is never allowed to overlap a frame.

Top module: `dacFrameWriter`

## Requirements
- R1: While reset is held and in the first idle cycle after it, syncN and ldacN are high, sclk is low and reqReady is high.
- R2: Each frame carries the 24-bit word {2'b11, chan[5:0], value[15:0]}. The command byte goes first, and every bit is sent MSB first. Each bit is valid at the rising edge of sclk.
- R3: While syncN is low, sclk has exactly 24 falling edges. sclk is never high while syncN is high, and syncN rises one system clock after the last falling edge.
- R4: Inside a frame, sclk is high for 2 system clocks and low for 2 system clocks per bit, which gives a period of 4. sclk idles low, and mosi does not change while sclk is high.
- R5: A request is accepted in a cycle where reqValid and reqReady are both high. When a frame starts, syncN falls at the accepting edge. reqReady then stays low for 97 system clocks and returns high in the same cycle that syncN returns high.
- R6: A request for a channel below 40 starts a frame if that channel has not been written since reset, or if its value differs from the last one sent. Otherwise it is accepted with no frame, and reqReady and syncN stay high.
- R7: A request whose channel index is 40 or above is accepted and dropped. No frame is sent and the shadow copies are unchanged.
- R8: Each commit pulse causes exactly one ldacN low pulse. That pulse lasts exactly 2 system clocks, and reqReady is low throughout it.
- R9: A commit that arrives during a frame is held until syncN is high again. ldacN and syncN are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Update request present |
| reqReady | output | 1 | Block can accept a request |
| reqChan | input | 6 | Channel index of the request |
| reqValue | input | 16 | New value for the channel |
| commit | input | 1 | Request a simultaneous output update |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data toward the DAC |
| syncN | output | 1 | Active-low frame strobe |
| ldacN | output | 1 | Active-low load strobe |

## Verification
The hardest case to reach is a commit that lands in the middle of a frame. The pulse must wait for syncN to rise and must not steal the idle slot from a later request. The stimulus reaches this case by launching a frame without waiting for it to finish, raising commit ten cycles later, and checking that the ldacN pulse falls strictly outside the low window of syncN. The skip logic is reached by replaying an entire 40-channel batch with identical values, so that every request must be absorbed silently. Before that replay, a zero written to a fresh channel confirms that the first write after reset is never skipped.

// File: rtl/dacPkg.sv
package dacPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_TAIL,
    ST_LOAD
  } ctrlState_t;

  typedef struct packed {
    logic load;
    logic shift;
  } dpCmd_t;
endpackage

// File: rtl/dacDatapath.sv
module dacDatapath
  import dacPkg::*;
#(
  parameter int unsigned CHAN_W     = 6,
  parameter int unsigned VAL_W      = 16,
  parameter int unsigned NUM_CHAN   = 40,
  parameter int unsigned CMD_PREFIX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [VAL_W-1:0]  reqValue,
  output logic              chanOk,
  output logic              valueNew,
  output logic              mosi
);
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned PREFIX_W = CMD_W - CHAN_W;
  localparam int unsigned FRAME_W  = CMD_W + VAL_W;

  logic [NUM_CHAN-1:0] hitVec;
  logic [NUM_CHAN-1:0] newVec;
  logic [FRAME_W-1:0]  shiftReg;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    logic [VAL_W-1:0] lastVal;
    logic             written;

    assign hitVec[g] = (reqChan == CHAN_W'(g));
    assign newVec[g] = !written || (lastVal != reqValue);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lastVal <= '0;
        written <= 1'b0;
      end else if (cmd.load && hitVec[g]) begin
        lastVal <= reqValue;
        written <= 1'b1;
      end
    end
  end

  assign chanOk   = |hitVec;
  assign valueNew = |(hitVec & newVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (cmd.load) begin
      shiftReg <= {PREFIX_W'(CMD_PREFIX), reqChan, reqValue};
    end else if (cmd.shift) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end
  end

  assign mosi = shiftReg[FRAME_W-1];

  // R6: a frame is only loaded for a channel in range with a changed value
  p_load_new_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> (chanOk && valueNew));

  // R4: load and shift never collide
  p_cmd_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.load && cmd.shift));
endmodule

// File: rtl/dacCtrl.sv
module dacCtrl
  import dacPkg::*;
#(
  parameter int unsigned FRAME_W  = 24,
  parameter int unsigned LDAC_LEN = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   commit,
  input  logic   chanOk,
  input  logic   valueNew,
  output logic   reqReady,
  output dpCmd_t cmd,
  output logic   sclk,
  output logic   syncN,
  output logic   ldacN
);
  localparam int unsigned BIT_W = $clog2(FRAME_W);
  localparam int unsigned LEN_W = $clog2(LDAC_LEN + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [LEN_W-1:0] LAST_LEN = LEN_W'(LDAC_LEN - 1);

  ctrlState_t       state;
  logic [1:0]       phase;
  logic [BIT_W-1:0] bitCnt;
  logic [LEN_W-1:0] ldacCnt;
  logic             commitPend;
  logic             accept;
  logic             launch;

  assign reqReady  = (state == ST_IDLE) && !commitPend;
  assign accept    = reqValid && reqReady;
  assign launch    = accept && chanOk && valueNew;
  assign cmd.load  = launch;
  assign cmd.shift = (state == ST_SHIFT) && (phase == 2'd3) && (bitCnt != LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= '0;
      bitCnt     <= '0;
      ldacCnt    <= '0;
      commitPend <= 1'b0;
      sclk       <= 1'b0;
      syncN      <= 1'b1;
      ldacN      <= 1'b1;
    end else begin
      commitPend <= commit || (commitPend && (state != ST_IDLE));
      unique case (state)
        ST_IDLE: begin
          if (commitPend) begin
            state   <= ST_LOAD;
            ldacN   <= 1'b0;
            ldacCnt <= '0;
          end else if (launch) begin
            state  <= ST_SHIFT;
            phase  <= '0;
            bitCnt <= '0;
            syncN  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          phase <= phase + 2'd1;
          sclk  <= (phase == 2'd1) || (phase == 2'd2);
          if (phase == 2'd3) begin
            if (bitCnt == LAST_BIT) state <= ST_TAIL;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          syncN <= 1'b1;
          state <= ST_IDLE;
        end
        ST_LOAD: begin
          if (ldacCnt == LAST_LEN) begin
            ldacN <= 1'b1;
            state <= ST_IDLE;
          end else begin
            ldacCnt <= ldacCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R9: load strobe never overlaps a frame
  p_sync_ldac_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    syncN || ldacN);

  // R5: ready only while the link is quiet
  p_ready_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (syncN && ldacN && !sclk));

  // R3: serial clock only toggles inside a frame
  p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !syncN);

  // R8: load pulse lasts more than one clock
  p_ldac_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ldacN) |=> !ldacN);
endmodule

// File: rtl/dacFrameWriter.sv
module dacFrameWriter
  import dacPkg::*;
#(
  parameter int unsigned CHAN_W     = 6,
  parameter int unsigned VAL_W      = 16,
  parameter int unsigned NUM_CHAN   = 40,
  parameter int unsigned CMD_PREFIX = 3,
  parameter int unsigned LDAC_LEN   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [VAL_W-1:0]  reqValue,
  input  logic              commit,
  output logic              sclk,
  output logic              mosi,
  output logic              syncN,
  output logic              ldacN
);
  localparam int unsigned FRAME_W = 8 + VAL_W;

  dpCmd_t dpCmd;
  logic   chanOk;
  logic   valueNew;

  dacCtrl #(
    .FRAME_W (FRAME_W),
    .LDAC_LEN(LDAC_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .commit  (commit),
    .chanOk  (chanOk),
    .valueNew(valueNew),
    .reqReady(reqReady),
    .cmd     (dpCmd),
    .sclk    (sclk),
    .syncN   (syncN),
    .ldacN   (ldacN)
  );

  dacDatapath #(
    .CHAN_W    (CHAN_W),
    .VAL_W     (VAL_W),
    .NUM_CHAN  (NUM_CHAN),
    .CMD_PREFIX(CMD_PREFIX)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (dpCmd),
    .reqChan (reqChan),
    .reqValue(reqValue),
    .chanOk  (chanOk),
    .valueNew(valueNew),
    .mosi    (mosi)
  );

  // R4: data is held while the serial clock is high
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi));

  // R5: a frame launches only on a handshake
  p_launch_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    dpCmd.load |-> (reqReady && reqValid));
endmodule

// File: tb/sim_dacFrameWriter.sv
module sim_dacFrameWriter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [5:0]  reqChan = '0;
  logic [15:0] reqValue = '0;
  logic        commit = 1'b0;
  logic        sclk, mosi, syncN, ldacN;

  always #5 clk = ~clk;

  dacFrameWriter u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqChan(reqChan), .reqValue(reqValue), .commit(commit),
    .sclk(sclk), .mosi(mosi), .syncN(syncN), .ldacN(ldacN)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [23:0] expQ[$];
  logic [15:0] refVal[64];
  bit          refSet[64];
  int expLdac = 0;
  int gotLdac = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor state
  logic prevSclk = 1'b0, prevSync = 1'b1, prevLdac = 1'b1, prevMosi = 1'b0;
  logic [23:0] shiftIn = '0;
  int falls = 0, run = 0, ldacRun = 0;
  bit seenHigh = 1'b0, badTiming = 1'b0, readyBad = 1'b0, syncBad = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (sclk != prevSclk) begin
        if (sclk) begin
          if (seenHigh && run != 2) badTiming = 1'b1;
          seenHigh = 1'b1;
          if (!syncN) shiftIn = {shiftIn[22:0], mosi};
        end else begin
          if (run != 2) badTiming = 1'b1;
          if (!syncN) falls++;
        end
        run = 1;
      end else begin
        run++;
        if (sclk && mosi != prevMosi) badTiming = 1'b1;
      end
      if (sclk && syncN) badTiming = 1'b1;
      if (syncN && !prevSync) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected frame", shiftIn, 0);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check(shiftIn == e, "R2", "frame word", shiftIn, e);
        end
        check(falls == 24, "R3", "falling edges in frame", falls, 24);
        check(!badTiming, "R4", "sclk timing and data hold", badTiming, 0);
        falls = 0; seenHigh = 1'b0; badTiming = 1'b0; shiftIn = '0;
      end
      if (!ldacN) begin
        ldacRun++;
        if (reqReady) readyBad = 1'b1;
        if (!syncN) syncBad = 1'b1;
      end
      if (ldacN && !prevLdac) begin
        gotLdac++;
        check(ldacRun == 2, "R8", "ldac pulse width", ldacRun, 2);
        check(!readyBad, "R8", "ready low during ldac", readyBad, 0);
        check(!syncBad, "R9", "ldac outside frame", syncBad, 0);
        ldacRun = 0; readyBad = 1'b0; syncBad = 1'b0;
      end
    end
    prevSclk = sclk; prevSync = syncN; prevLdac = ldacN; prevMosi = mosi;
  end

  task automatic sendReq(input logic [5:0] ch, input logic [15:0] v, input bit waitDone);
    bit expectFrame;
    int lowCnt;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expectFrame = (ch < 6'd40) && (!refSet[ch] || refVal[ch] != v);
    if (expectFrame) begin
      expQ.push_back({2'b11, ch, v});
      refSet[ch] = 1'b1;
      refVal[ch] = v;
    end
    reqValid = 1'b1; reqChan = ch; reqValue = v;
    @(negedge clk);
    reqValid = 1'b0;
    if (expectFrame) begin
      check(!reqReady && !syncN, "R5", "ready low and sync low after launch",
            {reqReady, syncN}, 0);
      if (waitDone) begin
        lowCnt = 1;
        @(negedge clk);
        while (!reqReady) begin
          lowCnt++;
          @(negedge clk);
        end
        check(lowCnt == 97, "R5", "ready low cycles", lowCnt, 97);
        check(syncN, "R5", "sync high when ready returns", syncN, 1);
      end
    end else if (ch < 6'd40) begin
      check(reqReady && syncN, "R6", "unchanged value skipped", {reqReady, syncN}, 3);
    end else begin
      check(reqReady && syncN, "R7", "out of range channel dropped", {reqReady, syncN}, 3);
    end
  endtask

  task automatic doCommit();
    @(negedge clk);
    commit = 1'b1;
    expLdac++;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      refSet[i] = 1'b0;
      refVal[i] = '0;
    end
    repeat (4) @(negedge clk);
    check(syncN && ldacN && !sclk, "R1", "outputs during reset", {syncN, ldacN, sclk}, 3'b110);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && syncN && ldacN && !sclk, "R1", "idle after reset",
          {reqReady, syncN, ldacN, sclk}, 4'b1110);

    // R2 / R3 / R4 / R5: single frames with varied patterns
    sendReq(6'd0, 16'h1234, 1'b1);
    sendReq(6'd39, 16'hFFFF, 1'b1);
    sendReq(6'd5, 16'h0000, 1'b1);
    sendReq(6'd17, 16'hA5C3, 1'b1);

    // R6: repeat skipped, change sent, first write of zero sent
    sendReq(6'd5, 16'h0000, 1'b1);
    sendReq(6'd5, 16'h0001, 1'b1);
    sendReq(6'd22, 16'h0000, 1'b1);

    // R7: out of range channels dropped, shadow untouched
    sendReq(6'd40, 16'h4444, 1'b1);
    sendReq(6'd63, 16'h5555, 1'b1);
    sendReq(6'd39, 16'hFFFF, 1'b1);

    // R8: commit while idle
    doCommit();
    waitIdle();

    // R9: commit during a frame is held
    sendReq(6'd3, 16'h0F0F, 1'b0);
    repeat (10) @(negedge clk);
    doCommit();
    waitIdle();

    // full batch then commit
    for (int c = 0; c < 40; c++) sendReq(6'(c), 16'(c * 16'h0101) ^ 16'h8000, 1'b0);
    waitIdle();
    doCommit();
    waitIdle();

    // R6: identical batch is fully skipped
    for (int c = 0; c < 40; c++) sendReq(6'(c), 16'(c * 16'h0101) ^ 16'h8000, 1'b0);
    waitIdle();

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R2", "all expected frames seen", expQ.size(), 0);
    check(gotLdac == expLdac, "R8", "ldac pulse count", gotLdac, expLdac);
    finishRun();
  end
endmodule